// File: doc/BRIEF.md
# Deferred Exception Poison Tracker

This block follows faults that speculative loads are allowed to hide. It holds one poison bit per architectural register. A speculative load that faults writes its destination as poisoned and does not trap. Any later operation that reads a poisoned register writes its own destination as poisoned and hides its own fault. The fault comes to light only when a check operation names a poisoned register. The block then asks the front end to redirect fetch to the recovery address that came with the check. A check on a clean register does nothing.

The block takes one operation descriptor per cycle. The descriptor carries a valid flag, a kind, two source registers, a destination register, a fault flag and a recovery target. The trap and redirect outputs are combinational from the current descriptor and the stored poison bits. Poison updates are registered at the clock edge, so an operation in the following cycle sees them. Data values and memory are handled elsewhere.

Top module: `poison_tracker`

## Requirements
- R1: After reset every register is clean, and `trap_o`, `redirect_o` and `redirect_addr_o` are low while no operation is issued.
- R2: A speculative load (kind 3) with `op_fault` high does not assert `trap_o`. It marks its destination poisoned, and this is visible to a check in the next cycle.
- R3: A speculative load without a fault writes its destination as clean, unless its address source (`src_a`) is poisoned.
- R4: An ALU operation (kind 1) writes its destination poison as the OR of the poison bits of `src_a` and `src_b`. When either source is poisoned, its `op_fault` does not assert `trap_o`.
- R5: A non-speculative write (ALU, or load with kind 2) whose sources are clean and that does not trap clears a previously poisoned destination.
- R6: A non-speculative load that faults and has a clean `src_a` asserts `trap_o` in the same cycle and leaves the destination's poison bit unchanged. With a poisoned `src_a`, it does not trap and instead poisons its destination.
- R7: A check (kind 4) on a clean `src_a` leaves `redirect_o` low. On a poisoned `src_a` it asserts `redirect_o` in the same cycle, with `redirect_addr_o` equal to `recov_target`. `redirect_addr_o` is zero whenever `redirect_o` is low.
- R8: A single check at the end of a dependent chain of ALU and load operations redirects when a speculative load anywhere earlier in the chain faulted.
- R9: Register 0 is never poisoned. A check on it never redirects, and reading it never propagates poison.
- R10: With `op_valid` low, or with a kind of 0, 5, 6 or 7, the block asserts no output and changes no poison bit.
- R11: An ALU operation with `op_fault` high and both sources clean asserts `trap_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Descriptor valid this cycle |
| op_kind | input | 3 | 0 none, 1 ALU, 2 load, 3 speculative load, 4 check, 5-7 none |
| src_a | input | REG_W | First source register (address for loads, register tested by check) |
| src_b | input | REG_W | Second source register (ALU only) |
| dst | input | REG_W | Destination register |
| op_fault | input | 1 | The operation would raise an exception |
| recov_target | input | ADDR_W | Recovery address carried by a check |
| trap_o | output | 1 | Immediate exception |
| redirect_o | output | 1 | Redirect fetch to recovery code |
| redirect_addr_o | output | ADDR_W | Recovery address when redirecting |

## Verification
The bench goes after propagation through several steps: a speculative load fault passes through ALU operations and a load into a final check. A tracker that cleared poison on every write, or dropped the second ALU source, would miss that redirect. It also tests a faulting non-speculative load into a poisoned destination. A design that cleared the bit there would lose the pending redirect. A design that suppressed the trap there would hide a real exception. Register 0 as a faulting speculative destination, invalid descriptors and unused kinds are exercised too. A design that decoded them loosely would poison a register or raise a spurious output.

// File: rtl/poison_tracker.sv
module poison_tracker #(
  parameter int NREG   = 32,
  parameter int ADDR_W = 32,
  parameter int REG_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_kind,
  input  logic [REG_W-1:0]  src_a,
  input  logic [REG_W-1:0]  src_b,
  input  logic [REG_W-1:0]  dst,
  input  logic              op_fault,
  input  logic [ADDR_W-1:0] recov_target,
  output logic              trap_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_addr_o
);
  localparam logic [2:0] K_ALU = 3'd1, K_LD = 3'd2, K_SLD = 3'd3, K_CHK = 3'd4;

  logic [NREG-1:0] poison_q;
  logic            wr_en, wr_val;

  wire pa = poison_q[src_a];
  wire pb = poison_q[src_b];

  always_comb begin
    wr_en      = 1'b0;
    wr_val     = 1'b0;
    trap_o     = 1'b0;
    redirect_o = 1'b0;
    if (op_valid) begin
      case (op_kind)
        K_ALU: begin
          wr_en  = 1'b1;
          wr_val = pa | pb;
          trap_o = op_fault & ~(pa | pb);
        end
        K_LD: begin
          if (pa) begin
            wr_en  = 1'b1;
            wr_val = 1'b1;
          end else if (op_fault) begin
            trap_o = 1'b1;
          end else begin
            wr_en = 1'b1;
          end
        end
        K_SLD: begin
          wr_en  = 1'b1;
          wr_val = op_fault | pa;
        end
        K_CHK: redirect_o = pa;
        default: ;
      endcase
    end
  end

  assign redirect_addr_o = redirect_o ? recov_target : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      poison_q <= '0;
    else if (wr_en && dst != '0)
      poison_q[dst] <= wr_val;
  end
endmodule

// File: rtl/poison_tracker_chk.sv
module poison_tracker_chk #(
  parameter int NREG   = 32,
  parameter int ADDR_W = 32,
  parameter int REG_W  = $clog2(NREG)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [2:0]        op_kind,
  input logic [REG_W-1:0]  src_a,
  input logic [REG_W-1:0]  dst,
  input logic              op_fault,
  input logic [NREG-1:0]   poison,
  input logic              trap_o,
  input logic              redirect_o
);
  a_r2_spec_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd3) |-> !trap_o);

  a_r2_spec_then_check: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd4 && $past(op_valid && op_kind == 3'd3 && op_fault && dst != '0)
     && src_a == $past(dst)) |-> redirect_o);

  a_r6_load_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd2 && op_fault && !poison[src_a]) |-> trap_o);

  a_r9_zero_never_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 3'd4 && src_a == '0) |-> !redirect_o);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (!trap_o && !redirect_o));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!op_valid) && $past(rst_n) |-> $stable(poison));

  a_r7_redirect_only_on_check: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (op_valid && op_kind == 3'd4));
endmodule

bind poison_tracker poison_tracker_chk #(.NREG(NREG), .ADDR_W(ADDR_W), .REG_W(REG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .src_a(src_a), .dst(dst), .op_fault(op_fault), .poison(poison_q),
  .trap_o(trap_o), .redirect_o(redirect_o)
);

// File: tb/poison_tracker_tb_top.sv
module poison_tracker_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_fault = 0;
  logic [2:0] op_kind = 0;
  logic [4:0] src_a = 0, src_b = 0, dst = 0;
  logic [AW-1:0] recov_target = 0;
  logic trap_o, redirect_o;
  logic [AW-1:0] redirect_addr_o;

  int n_run = 0, n_fail = 0;
  logic s_trap, s_redir;
  logic [AW-1:0] s_addr;

  always #(CLK_P/2) clk = ~clk;

  poison_tracker #(.NREG(32), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .src_a(src_a), .src_b(src_b), .dst(dst), .op_fault(op_fault),
    .recov_target(recov_target), .trap_o(trap_o), .redirect_o(redirect_o),
    .redirect_addr_o(redirect_addr_o));

  task automatic issue(input logic v, input logic [2:0] k, input logic [4:0] a,
                       input logic [4:0] b, input logic [4:0] d, input logic f,
                       input logic [AW-1:0] t);
    @(negedge clk);
    op_valid = v; op_kind = k; src_a = a; src_b = b; dst = d; op_fault = f; recov_target = t;
    #1;
    s_trap = trap_o; s_redir = redirect_o; s_addr = redirect_addr_o;
    @(posedge clk);
    #1;
    op_valid = 0; op_kind = 0; op_fault = 0;
  endtask

  task automatic expect1(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic expect_addr(input string req, input logic [AW-1:0] exp);
    n_run++;
    if (s_addr !== exp) begin
      n_fail++;
      $display("FAIL %s redirect address: actual %h expected %h", req, s_addr, exp);
    end
  endtask

  task automatic check_reg(input string req, input logic [4:0] r, input logic poisoned);
    issue(1, 3'd4, r, 0, 0, 0, 32'h1000 + r);
    expect1(req, $sformatf("check r%0d redirect", r), s_redir, poisoned);
    expect_addr(req, poisoned ? 32'h1000 + r : '0);
  endtask

  task automatic t_reset();
    #1;
    expect1("R1", "trap after reset", trap_o, 0);
    expect1("R1", "redirect after reset", redirect_o, 0);
    check_reg("R1", 5'd5, 0);
    check_reg("R1", 5'd31, 0);
  endtask

  task automatic t_spec();
    issue(1, 3'd3, 5'd1, 0, 5'd3, 1, 0);
    expect1("R2", "spec load fault trap", s_trap, 0);
    check_reg("R2", 5'd3, 1);
    issue(1, 3'd3, 5'd0, 0, 5'd4, 0, 0);
    check_reg("R3", 5'd4, 0);
    issue(1, 3'd3, 5'd3, 0, 5'd20, 0, 0);
    check_reg("R3", 5'd20, 1);
  endtask

  task automatic t_prop();
    issue(1, 3'd1, 5'd3, 5'd0, 5'd6, 0, 0);
    check_reg("R4", 5'd6, 1);
    issue(1, 3'd1, 5'd1, 5'd3, 5'd7, 1, 0);
    expect1("R4", "alu fault on poisoned source trap", s_trap, 0);
    check_reg("R4", 5'd7, 1);
  endtask

  task automatic t_chain();
    issue(1, 3'd3, 5'd2, 0, 5'd8, 1, 0);
    issue(1, 3'd1, 5'd8, 5'd1, 5'd9, 0, 0);
    issue(1, 3'd1, 5'd2, 5'd9, 5'd10, 0, 0);
    issue(1, 3'd2, 5'd10, 0, 5'd11, 1, 0);
    expect1("R8", "load fault on poisoned address trap", s_trap, 0);
    check_reg("R8", 5'd11, 1);
  endtask

  task automatic t_clear();
    issue(1, 3'd1, 5'd1, 5'd2, 5'd3, 0, 0);
    check_reg("R5", 5'd3, 0);
    issue(1, 3'd2, 5'd1, 0, 5'd6, 0, 0);
    check_reg("R5", 5'd6, 0);
  endtask

  task automatic t_trap();
    issue(1, 3'd3, 5'd1, 0, 5'd12, 1, 0);
    issue(1, 3'd2, 5'd1, 0, 5'd12, 1, 0);
    expect1("R6", "load fault trap", s_trap, 1);
    check_reg("R6", 5'd12, 1);
    issue(1, 3'd2, 5'd12, 0, 5'd13, 1, 0);
    expect1("R6", "load fault poisoned address trap", s_trap, 0);
    check_reg("R6", 5'd13, 1);
  endtask

  task automatic t_alu_trap();
    issue(1, 3'd1, 5'd1, 5'd2, 5'd14, 1, 0);
    expect1("R11", "alu fault clean trap", s_trap, 1);
  endtask

  task automatic t_zero();
    issue(1, 3'd3, 5'd1, 0, 5'd0, 1, 0);
    check_reg("R9", 5'd0, 0);
    issue(1, 3'd1, 5'd0, 5'd0, 5'd15, 0, 0);
    check_reg("R9", 5'd15, 0);
  endtask

  task automatic t_ignore();
    issue(0, 3'd3, 5'd1, 0, 5'd16, 1, 0);
    expect1("R10", "invalid trap", s_trap, 0);
    check_reg("R10", 5'd16, 0);
    issue(1, 3'd6, 5'd1, 0, 5'd17, 1, 0);
    expect1("R10", "unused kind trap", s_trap, 0);
    check_reg("R10", 5'd17, 0);
    issue(0, 3'd4, 5'd3, 0, 0, 0, 32'hBEEF);
    expect1("R10", "invalid check redirect", s_redir, 0);
    expect_addr("R7", '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_spec();
    t_prop();
    t_chain();
    t_clear();
    t_trap();
    t_alu_trap();
    t_zero();
    t_ignore();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule